// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end of a NOR-style flash memory. The host issues bus write cycles, each a 16-bit data word with an address. The block decodes one-cycle and two-cycle command sequences from these writes and tracks the chip state: ready, setup, busy, suspended, and program-suspended inside an erase suspend. It sends start, suspend and resume pulses to an abstract program/erase engine. That engine reports completion with a single done pulse.

The block also drives a read-output select that picks array data or the status byte. Sequences that are illegal or inconsistent never reach the engine. Instead they raise a sticky sequence-error flag. One case is dropped on purpose with no error: an erase confirm issued while a program is suspended is ambiguous, so the block discards it.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset the status byte reads 0x80, the read select is array (rd_status=0), and no engine pulse is high.
- R2: Command codes come from wr_data[7:0], and the upper byte is ignored. Code 0x40 followed by any second write to the same partition (partition = wr_addr[22:19]) pulses eng_start for one cycle with eng_op=0. eng_addr and eng_data carry the second write, and status bit 7 (ready) drops to 0.
- R3: Code 0x20 followed by 0xD0 to the same partition starts an erase (eng_op=1). Any other second code sets the sequence error and starts nothing.
- R4: Code 0xC0 followed by any second write to the same partition starts a one-time-programmable write (eng_op=2).
- R5: Code 0x60 followed by 0x01, 0x2F or 0x03 starts lock (eng_op=3), lock-down (eng_op=4) or configuration write (eng_op=5). Any other second code is a sequence error.
- R6: If the second write of a two-cycle command goes to a different partition, nothing starts. Status bit 4 (sequence error) sets, and the machine returns to the state it left: ready, or erase suspend.
- R7: A code outside the command set for the current state sets status bit 4 and leaves the state unchanged. Code 0x50 clears bit 4 and leaves the read select unchanged.
- R8: While busy, only 0xB0 (during program or erase) and 0x70 have any effect. Every other write is ignored.
- R9: 0xB0 during a program or erase pulses eng_suspend and enters program suspend (status bit 2) or erase suspend (status bit 6) with bit 7 set. 0xD0 in a suspend state pulses eng_resume and returns to busy.
- R10: In erase suspend, 0x40 plus a data write starts a program. That program can itself be suspended (bits 6 and 2 both set) and resumed, and its completion returns to erase suspend.
- R11: In program suspend, 0x20 is accepted, but the next write, whatever it carries, is discarded. No engine pulse, no error, and the state stays program suspended.
- R12: eng_done in a busy state returns to ready, or to erase suspend for a program started inside erase suspend. It takes priority over a write in the same cycle. eng_done in any other state is ignored.
- R13: 0xFF selects array output and 0x70 selects status. Accepted setup, start, suspend, resume and error events select status. Completion does not change the select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write cycle strobe |
| wr_addr | input | 23 | Write address, partition in the top four bits |
| wr_data | input | 16 | Write data / command code |
| eng_done | input | 1 | Engine completion pulse |
| eng_start | output | 1 | Engine start pulse |
| eng_op | output | 3 | Operation of the last start |
| eng_addr | output | 23 | Address captured with the start |
| eng_data | output | 16 | Data captured with the start |
| eng_suspend | output | 1 | Engine suspend pulse |
| eng_resume | output | 1 | Engine resume pulse |
| rd_status | output | 1 | Read select: 1 status, 0 array |
| status | output | 8 | Status byte: 7 ready, 6 erase suspended, 4 sequence error, 2 program suspended |

## Verification
The bench targets the ambiguous erase-setup-then-confirm while program is suspended. A design that gets this wrong would resume the program or start an erase. It also targets a second cycle aimed at another partition, which a careless design would act on. Nested suspend is exercised through a full program suspend/resume/complete inside an erase suspend. A wrong design there would fall back to ready rather than erase suspend. Completion arriving with a suspend in the same cycle checks that no stale suspend pulse escapes. Further cases are writes during busy, which must not disturb the read select, and clear-status, which must not move the select.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
   localparam logic [7:0] CODE_PGM   = 8'h40;
   localparam logic [7:0] CODE_ERS   = 8'h20;
   localparam logic [7:0] CODE_CONF  = 8'hD0;
   localparam logic [7:0] CODE_OTP   = 8'hC0;
   localparam logic [7:0] CODE_CFG   = 8'h60;
   localparam logic [7:0] CODE_LK    = 8'h01;
   localparam logic [7:0] CODE_LKD   = 8'h2F;
   localparam logic [7:0] CODE_WCR   = 8'h03;
   localparam logic [7:0] CODE_RDA   = 8'hFF;
   localparam logic [7:0] CODE_RDS   = 8'h70;
   localparam logic [7:0] CODE_CLR   = 8'h50;
   localparam logic [7:0] CODE_SUS   = 8'hB0;

   localparam int STAT_W      = 8;
   localparam int BIT_READY   = 7;
   localparam int BIT_ESUS    = 6;
   localparam int BIT_SEQERR  = 4;
   localparam int BIT_PSUS    = 2;

   typedef enum logic [3:0] {
      K_BAD, K_PGM, K_ERS, K_CONF, K_OTP, K_CFG, K_LK, K_LKD,
      K_WCR, K_RDA, K_RDS, K_CLR, K_SUS
   } kind_e;

   typedef enum logic [3:0] {
      S_RDY, S_PSU, S_ESU, S_OSU, S_CSU, S_PBSY, S_EBSY, S_OBSY,
      S_CBSY, S_PSUS, S_ESUS, S_PSU_E, S_PBSY_E, S_PSUS_E, S_EDROP
   } st_e;

   typedef enum logic [2:0] {
      OP_PGM, OP_ERS, OP_OTP, OP_LOCK, OP_LDN, OP_WCFG
   } op_e;
endpackage

// File: rtl/fcmd_decode.sv
module fcmd_decode
   import fcmd_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter bit STRICT_HI = 1'b0
) (
   input  logic [DATA_W-1:0] data_i,
   output kind_e             kind_o
);
   logic  hi_ok;
   kind_e raw;

   initial begin : a_dec_params
      assert (DATA_W >= 8);
   end

   generate
      if (STRICT_HI && DATA_W > 8) begin : g_strict
         assign hi_ok = (data_i[DATA_W-1:8] == '0) ||
                        (data_i[DATA_W-1:8] == {(DATA_W-8){1'b1}});
      end else begin : g_loose
         assign hi_ok = 1'b1;
         if (DATA_W > 8) begin : g_drop
            logic unused_hi;
            assign unused_hi = ^data_i[DATA_W-1:8];
         end
      end
   endgenerate

   always_comb begin
      case (data_i[7:0])
         CODE_PGM:  raw = K_PGM;
         CODE_ERS:  raw = K_ERS;
         CODE_CONF: raw = K_CONF;
         CODE_OTP:  raw = K_OTP;
         CODE_CFG:  raw = K_CFG;
         CODE_LK:   raw = K_LK;
         CODE_LKD:  raw = K_LKD;
         CODE_WCR:  raw = K_WCR;
         CODE_RDA:  raw = K_RDA;
         CODE_RDS:  raw = K_RDS;
         CODE_CLR:  raw = K_CLR;
         CODE_SUS:  raw = K_SUS;
         default:   raw = K_BAD;
      endcase
      kind_o = hi_ok ? raw : K_BAD;
   end
endmodule

// File: rtl/fcmd_seq.sv
module fcmd_seq
   import fcmd_pkg::*;
#(
   parameter int ADDR_W = 23,
   parameter int PART_W = 4,
   parameter int DATA_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  kind_e             kind_i,
   input  logic              eng_done_i,
   output logic              eng_start_o,
   output logic [2:0]        eng_op_o,
   output logic [ADDR_W-1:0] eng_addr_o,
   output logic [DATA_W-1:0] eng_data_o,
   output logic              eng_suspend_o,
   output logic              eng_resume_o,
   output logic              busy_o,
   output logic              esus_o,
   output logic              psus_o,
   output logic              ev_err_o,
   output logic              ev_clr_o,
   output logic              ev_stat_o,
   output logic              ev_arr_o
);
   localparam int PART_LSB = ADDR_W - PART_W;

   st_e               st_q, st_n;
   op_e               op_q, op_n;
   logic [PART_W-1:0] part_q, wr_part;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              start_q, sus_q, res_q;
   logic              start_n, sus_n, res_n;
   logic              same_part, base_st, setup_st, busy_st;
   st_e               origin;

   initial begin : a_seq_params
      assert (PART_W >= 1 && PART_W < ADDR_W);
   end

   assign wr_part   = wr_addr_i[ADDR_W-1:PART_LSB];
   assign same_part = (wr_part == part_q);
   assign origin    = (st_q == S_PSU_E) ? S_ESUS : S_RDY;

   always_comb begin
      base_st  = st_q inside {S_RDY, S_PSUS, S_ESUS, S_PSUS_E};
      setup_st = st_q inside {S_PSU, S_ESU, S_OSU, S_CSU, S_PSU_E};
      busy_st  = st_q inside {S_PBSY, S_EBSY, S_OBSY, S_CBSY, S_PBSY_E};
   end

   always_comb begin
      st_n      = st_q;
      op_n      = op_q;
      start_n   = 1'b0;
      sus_n     = 1'b0;
      res_n     = 1'b0;
      ev_err_o  = 1'b0;
      ev_clr_o  = 1'b0;
      ev_stat_o = 1'b0;
      ev_arr_o  = 1'b0;
      if (eng_done_i && busy_st) begin
         st_n = (st_q == S_PBSY_E) ? S_ESUS : S_RDY;
      end else if (wr_en_i) begin
         if (base_st) begin
            ev_arr_o  = (kind_i == K_RDA);
            ev_stat_o = !(kind_i inside {K_RDA, K_CLR});
            case (kind_i)
               K_RDA, K_RDS: ;
               K_CLR: ev_clr_o = 1'b1;
               K_PGM: begin
                  if (st_q == S_RDY)       st_n = S_PSU;
                  else if (st_q == S_ESUS) st_n = S_PSU_E;
                  else                     ev_err_o = 1'b1;
               end
               K_ERS: begin
                  if (st_q == S_RDY)       st_n = S_ESU;
                  else if (st_q == S_PSUS) st_n = S_EDROP;
                  else                     ev_err_o = 1'b1;
               end
               K_OTP: begin
                  if (st_q == S_RDY) st_n = S_OSU;
                  else               ev_err_o = 1'b1;
               end
               K_CFG: begin
                  if (st_q == S_RDY) st_n = S_CSU;
                  else               ev_err_o = 1'b1;
               end
               K_CONF: begin
                  res_n = 1'b1;
                  case (st_q)
                     S_PSUS:   st_n = S_PBSY;
                     S_ESUS:   st_n = S_EBSY;
                     S_PSUS_E: st_n = S_PBSY_E;
                     default: begin
                        res_n    = 1'b0;
                        ev_err_o = 1'b1;
                     end
                  endcase
               end
               default: ev_err_o = 1'b1;
            endcase
         end else if (setup_st) begin
            ev_stat_o = 1'b1;
            if (!same_part) begin
               ev_err_o = 1'b1;
               st_n     = origin;
            end else begin
               case (st_q)
                  S_PSU:   begin start_n = 1'b1; op_n = OP_PGM; st_n = S_PBSY; end
                  S_PSU_E: begin start_n = 1'b1; op_n = OP_PGM; st_n = S_PBSY_E; end
                  S_OSU:   begin start_n = 1'b1; op_n = OP_OTP; st_n = S_OBSY; end
                  S_ESU: begin
                     if (kind_i == K_CONF) begin
                        start_n = 1'b1; op_n = OP_ERS; st_n = S_EBSY;
                     end else begin
                        ev_err_o = 1'b1; st_n = S_RDY;
                     end
                  end
                  default: begin
                     st_n = S_CBSY;
                     case (kind_i)
                        K_LK:  begin start_n = 1'b1; op_n = OP_LOCK; end
                        K_LKD: begin start_n = 1'b1; op_n = OP_LDN;  end
                        K_WCR: begin start_n = 1'b1; op_n = OP_WCFG; end
                        default: begin ev_err_o = 1'b1; st_n = S_RDY; end
                     endcase
                  end
               endcase
            end
         end else if (st_q == S_EDROP) begin
            st_n = S_PSUS;
         end else begin
            if (kind_i == K_SUS && st_q inside {S_PBSY, S_EBSY, S_PBSY_E}) begin
               sus_n     = 1'b1;
               ev_stat_o = 1'b1;
               case (st_q)
                  S_PBSY:  st_n = S_PSUS;
                  S_EBSY:  st_n = S_ESUS;
                  default: st_n = S_PSUS_E;
               endcase
            end else if (kind_i == K_RDS) begin
               ev_stat_o = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q    <= S_RDY;
         op_q    <= OP_PGM;
         part_q  <= '0;
         addr_q  <= '0;
         data_q  <= '0;
         start_q <= 1'b0;
         sus_q   <= 1'b0;
         res_q   <= 1'b0;
      end else begin
         st_q    <= st_n;
         op_q    <= op_n;
         start_q <= start_n;
         sus_q   <= sus_n;
         res_q   <= res_n;
         if (base_st && wr_en_i) part_q <= wr_part;
         if (start_n) begin
            addr_q <= wr_addr_i;
            data_q <= wr_data_i;
         end
      end
   end

   assign eng_start_o   = start_q;
   assign eng_suspend_o = sus_q;
   assign eng_resume_o  = res_q;
   assign eng_op_o      = op_q;
   assign eng_addr_o    = addr_q;
   assign eng_data_o    = data_q;
   assign busy_o        = busy_st;
   assign esus_o        = st_q inside {S_ESUS, S_PSU_E, S_PBSY_E, S_PSUS_E};
   assign psus_o        = st_q inside {S_PSUS, S_EDROP, S_PSUS_E};

   a_r11_drop_second: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == S_EDROP && wr_en_i) |=> (st_q == S_PSUS && !eng_start_o && !eng_resume_o));
   a_r8_busy_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_st && wr_en_i) |=> !eng_start_o);
   a_r9_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({eng_start_o, eng_suspend_o, eng_resume_o}));
   a_r6_other_part: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (setup_st && wr_en_i && !same_part) |=> (!eng_start_o && !busy_o));
endmodule

// File: rtl/fcmd_status.sv
module fcmd_status
   import fcmd_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              busy_i,
   input  logic              esus_i,
   input  logic              psus_i,
   input  logic              ev_err_i,
   input  logic              ev_clr_i,
   input  logic              ev_stat_i,
   input  logic              ev_arr_i,
   output logic [STAT_W-1:0] status_o,
   output logic              rd_status_o
);
   logic err_q, sel_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         err_q <= 1'b0;
         sel_q <= 1'b0;
      end else begin
         if (ev_err_i)      err_q <= 1'b1;
         else if (ev_clr_i) err_q <= 1'b0;
         if (ev_arr_i)       sel_q <= 1'b0;
         else if (ev_stat_i) sel_q <= 1'b1;
      end
   end

   always_comb begin
      status_o             = '0;
      status_o[BIT_READY]  = !busy_i;
      status_o[BIT_ESUS]   = esus_i;
      status_o[BIT_SEQERR] = err_q;
      status_o[BIT_PSUS]   = psus_i;
   end
   assign rd_status_o = sel_q;

   a_r7_clear_drops_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_clr_i && !ev_err_i) |=> !status_o[BIT_SEQERR]);
   a_r13_array_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_arr_i |=> !rd_status_o);
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
   import fcmd_pkg::*;
#(
   parameter int ADDR_W    = 23,
   parameter int PART_W    = 4,
   parameter int DATA_W    = 16,
   parameter bit STRICT_HI = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              eng_done,
   output logic              eng_start,
   output logic [2:0]        eng_op,
   output logic [ADDR_W-1:0] eng_addr,
   output logic [DATA_W-1:0] eng_data,
   output logic              eng_suspend,
   output logic              eng_resume,
   output logic              rd_status,
   output logic [7:0]        status
);
   kind_e kind;
   logic  busy, esus, psus, ev_err, ev_clr, ev_stat, ev_arr;

   fcmd_decode #(.DATA_W(DATA_W), .STRICT_HI(STRICT_HI)) u_dec (
      .data_i (wr_data),
      .kind_o (kind)
   );

   fcmd_seq #(.ADDR_W(ADDR_W), .PART_W(PART_W), .DATA_W(DATA_W)) u_seq (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .wr_en_i       (wr_en),
      .wr_addr_i     (wr_addr),
      .wr_data_i     (wr_data),
      .kind_i        (kind),
      .eng_done_i    (eng_done),
      .eng_start_o   (eng_start),
      .eng_op_o      (eng_op),
      .eng_addr_o    (eng_addr),
      .eng_data_o    (eng_data),
      .eng_suspend_o (eng_suspend),
      .eng_resume_o  (eng_resume),
      .busy_o        (busy),
      .esus_o        (esus),
      .psus_o        (psus),
      .ev_err_o      (ev_err),
      .ev_clr_o      (ev_clr),
      .ev_stat_o     (ev_stat),
      .ev_arr_o      (ev_arr)
   );

   fcmd_status u_stat (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .busy_i      (busy),
      .esus_i      (esus),
      .psus_i      (psus),
      .ev_err_i    (ev_err),
      .ev_clr_i    (ev_clr),
      .ev_stat_i   (ev_stat),
      .ev_arr_i    (ev_arr),
      .status_o    (status),
      .rd_status_o (rd_status)
   );

   a_r12_done_to_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && !status[BIT_READY]) |=> (status[BIT_READY] && !eng_suspend));
   a_r2_start_is_busy: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> !status[BIT_READY]);
   a_r9_suspend_state: assert property (@(posedge clk) disable iff (!rst_n)
      eng_suspend |-> (status[BIT_READY] && (status[BIT_PSUS] || status[BIT_ESUS])));
   a_r7_err_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[BIT_SEQERR]) |-> $past(wr_en));
endmodule

// File: tb/flash_cmd_fsm_tb.sv
`timescale 1ns/1ps
module flash_cmd_fsm_tb_top;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        wr_en = 1'b0, eng_done = 1'b0;
   logic [22:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        eng_start, eng_suspend, eng_resume, rd_status;
   logic [2:0]  eng_op;
   logic [22:0] eng_addr;
   logic [15:0] eng_data;
   logic [7:0]  status;

   int total = 0, bad = 0;
   int ms = 0;
   logic [3:0]  m_part = '0;
   logic        e_sel = 0, e_err = 0, e_start = 0, e_sus = 0, e_res = 0;
   logic [2:0]  e_op = '0;
   logic [22:0] e_addr = '0;
   logic [15:0] e_data = '0;

   always #10 clk = ~clk;

   flash_cmd_fsm dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .eng_done(eng_done), .eng_start(eng_start), .eng_op(eng_op), .eng_addr(eng_addr),
      .eng_data(eng_data), .eng_suspend(eng_suspend), .eng_resume(eng_resume),
      .rd_status(rd_status), .status(status)
   );

   function automatic logic [22:0] mk(input logic [3:0] p, input logic [18:0] lo);
      return {p, lo};
   endfunction

   function automatic logic [7:0] exp_status();
      logic [7:0] s = '0;
      s[7] = !(ms inside {5, 6, 7, 8, 12});
      s[6] = ms inside {10, 11, 12, 13};
      s[4] = e_err;
      s[2] = ms inside {9, 13, 14};
      return s;
   endfunction

   // states: 0 ready 1 pgm setup 2 erase setup 3 otp setup 4 cfg setup 5 pgm busy
   // 6 erase busy 7 otp busy 8 cfg busy 9 pgm susp 10 erase susp 11 pgm setup in es
   // 12 pgm busy in es 13 pgm susp in es 14 discard after erase setup in pgm susp
   task automatic model(input bit w, input logic [22:0] a, input logic [15:0] d, input bit dn);
      logic [7:0] c;
      bit same;
      c = d[7:0];
      same = (a[22:19] == m_part);
      e_start = 0; e_sus = 0; e_res = 0;
      if (dn && (ms inside {5, 6, 7, 8, 12})) begin
         ms = (ms == 12) ? 10 : 0;
      end else if (w) begin
         if (ms inside {0, 9, 10, 13}) begin
            m_part = a[22:19];
            if (c == 8'hFF) e_sel = 0;
            else if (c != 8'h50) e_sel = 1;
            case (c)
               8'h50: e_err = 0;
               8'hFF, 8'h70: ;
               8'h40: if (ms == 0) ms = 1; else if (ms == 10) ms = 11; else e_err = 1;
               8'h20: if (ms == 0) ms = 2; else if (ms == 9) ms = 14; else e_err = 1;
               8'hC0: if (ms == 0) ms = 3; else e_err = 1;
               8'h60: if (ms == 0) ms = 4; else e_err = 1;
               8'hD0: begin
                  if (ms == 0) e_err = 1;
                  else begin e_res = 1; ms = (ms == 9) ? 5 : (ms == 10) ? 6 : 12; end
               end
               default: e_err = 1;
            endcase
         end else if (ms inside {1, 2, 3, 4, 11}) begin
            e_sel = 1;
            if (!same) begin e_err = 1; ms = (ms == 11) ? 10 : 0; end
            else begin
               e_addr = a; e_data = d;
               case (ms)
                  1: begin e_start = 1; e_op = 0; ms = 5; end
                  11: begin e_start = 1; e_op = 0; ms = 12; end
                  3: begin e_start = 1; e_op = 2; ms = 7; end
                  2: if (c == 8'hD0) begin e_start = 1; e_op = 1; ms = 6; end
                     else begin e_err = 1; ms = 0; end
                  default: begin
                     if (c == 8'h01) begin e_start = 1; e_op = 3; ms = 8; end
                     else if (c == 8'h2F) begin e_start = 1; e_op = 4; ms = 8; end
                     else if (c == 8'h03) begin e_start = 1; e_op = 5; ms = 8; end
                     else begin e_err = 1; ms = 0; end
                  end
               endcase
            end
         end else if (ms == 14) begin
            ms = 9;
         end else begin
            if (c == 8'hB0 && (ms inside {5, 6, 12})) begin
               e_sus = 1; e_sel = 1;
               ms = (ms == 5) ? 9 : (ms == 6) ? 10 : 13;
            end else if (c == 8'h70) e_sel = 1;
         end
      end
   endtask

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      chk(tag, "status", {24'd0, status}, {24'd0, exp_status()});
      chk(tag, "rd_status", {31'd0, rd_status}, {31'd0, e_sel});
      chk(tag, "eng_start", {31'd0, eng_start}, {31'd0, e_start});
      chk(tag, "eng_suspend", {31'd0, eng_suspend}, {31'd0, e_sus});
      chk(tag, "eng_resume", {31'd0, eng_resume}, {31'd0, e_res});
      if (e_start) begin
         chk(tag, "eng_op", {29'd0, eng_op}, {29'd0, e_op});
         chk(tag, "eng_addr", {9'd0, eng_addr}, {9'd0, e_addr});
         chk(tag, "eng_data", {16'd0, eng_data}, {16'd0, e_data});
      end
   endtask

   task automatic cyc(input bit w, input logic [22:0] a, input logic [15:0] d, input bit dn, input string tag);
      wr_en = w; wr_addr = a; wr_data = d; eng_done = dn;
      model(w, a, d, dn);
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic wr(input logic [15:0] d, input string tag);
      cyc(1'b1, mk(4'd3, 19'h01234), d, 1'b0, tag);
   endtask

   task automatic done(input string tag);
      cyc(1'b0, '0, '0, 1'b1, tag);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [7:0] codes [13];
      codes = '{8'h40, 8'h20, 8'hD0, 8'hC0, 8'h60, 8'h01, 8'h2F, 8'h03,
                8'hFF, 8'h70, 8'h50, 8'hB0, 8'h00};
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");
      // illegal code, clear, array select
      wr(16'h1234, "R7");
      wr(16'h0050, "R7");
      wr(16'h00FF, "R13");
      // program with upper byte noise
      wr(16'hAB40, "R2");
      wr(16'h5A5A, "R2");
      wr(16'h00FF, "R8");
      wr(16'h0040, "R8");
      done("R12");
      done("R12");
      // erase, suspend, nested program
      wr(16'h0020, "R3");
      wr(16'h00D0, "R3");
      wr(16'h00B0, "R9");
      wr(16'h0040, "R10");
      wr(16'hC3C3, "R10");
      wr(16'h00B0, "R10");
      wr(16'h00D0, "R10");
      done("R10");
      wr(16'h00D0, "R9");
      cyc(1'b1, mk(4'd3, 19'h00010), 16'h00B0, 1'b1, "R12");
      // erase with wrong confirm
      wr(16'h0020, "R3");
      wr(16'h0030, "R3");
      wr(16'h0050, "R7");
      // partition mismatch
      wr(16'h0040, "R6");
      cyc(1'b1, mk(4'd4, 19'h00001), 16'h1111, 1'b0, "R6");
      wr(16'h0050, "R6");
      wr(16'h00FF, "R13");
      // otp and configuration commands
      wr(16'h00C0, "R4");
      wr(16'h2222, "R4");
      done("R4");
      wr(16'h0060, "R5"); wr(16'h0001, "R5"); done("R5");
      wr(16'h0060, "R5"); wr(16'h002F, "R5"); done("R5");
      wr(16'h0060, "R5"); wr(16'h0003, "R5"); wr(16'h00B0, "R8"); done("R5");
      wr(16'h0060, "R5"); wr(16'h0077, "R5"); wr(16'h0050, "R5");
      // discarded confirm in program suspend
      wr(16'h0040, "R11"); wr(16'h3333, "R11"); wr(16'h00B0, "R11");
      wr(16'h0020, "R11"); wr(16'h00D0, "R11");
      wr(16'h0070, "R13");
      wr(16'h00D0, "R9");
      done("R12");
      // erase suspend with partition mismatch in nested program
      wr(16'h0020, "R3"); wr(16'h00D0, "R3"); wr(16'h00B0, "R9");
      wr(16'h0040, "R6");
      cyc(1'b1, mk(4'd9, 19'h00002), 16'h4444, 1'b0, "R6");
      wr(16'h00D0, "R9"); done("R12"); wr(16'h0050, "R7");
      // constrained random
      for (int i = 0; i < 6000; i++) begin
         bit w, dn;
         logic [15:0] d;
         logic [3:0]  p;
         w  = ($urandom % 4) != 0;
         dn = ($urandom % 5) == 0;
         d  = {8'($urandom), codes[$urandom % 13]};
         if (($urandom % 10) == 0) d = 16'($urandom);
         p  = (($urandom % 5) == 0) ? 4'($urandom) : 4'd3;
         cyc(w, mk(p, 19'($urandom)), d, dn, "RND");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule